// File: doc/BRIEF.md
# I2C SCL Phase Timer

This block times the two halves of the serial clock for an I2C master. Out of the system clock it makes a request for the SCL line level: low requests a pull-down, high requests release. It also gives two single-cycle strobes that a bit engine uses. One strobe marks the last cycle of each low half, which is where SDA may change. The other marks the middle of each high half, which is where SDA is sampled.

Each half lasts its own 8-bit divider multiplied by a power of two, plus three cycles. The host sets the power-of-two exponent, and any exponent above four is treated as four. The host works out the divider values and drives them as levels. The block copies them only when a low half begins, so a period that has already started keeps its timing.

The counter for the high half advances only in cycles where the line is actually seen high. A slave that holds SCL low therefore stretches that half. While the block is disabled or in reset it releases the line and stays silent.

Top module: `i2c_scl_gen`

## Requirements
- R1: With exponent e (after R3), each low half drives `scl_req` to 0 for exactly `low_div * 2^e + 3` consecutive cycles.
- R2: With no stretching, each high half holds `scl_req` at 1 for exactly `high_div * 2^e + 3` cycles, after which the next low half begins.
- R3: `exp_sel` values 5, 6 and 7 produce the same timing as value 4. Values 0 to 4 are used as given.
- R4: The high-half count advances only in cycles where `scl_sense` is 1. If the line is held low for S cycles at the start of the high half, that half lasts `high_div * 2^e + 3 + S` cycles.
- R5: `low_div`, `high_div` and `exp_sel` are captured on the clock edge that starts a low half. Both halves of that period use the captured values, and changes made during the period affect only later periods.
- R6: `tick_low_end` is 1 for exactly one cycle per low half: its last cycle, with `scl_req` at 0.
- R7: `tick_high_mid` is 1 for exactly one cycle per high half. That cycle is the one in which floor(H/2) counted cycles have already passed, where H is the unstretched high length. `scl_sense` is 1 in that cycle.
- R8: In any cycle with `enable` at 0, `scl_req` is 1 and both strobes are 0. When `enable` returns to 1, the next cycle starts a full low half using freshly captured values.
- R9: Asserting `rst_n` low forces `scl_req` to 1 and both strobes to 0 at once, even when `enable` is 1. Release is synchronised over two clock edges, after which a full low half starts.
- R10: A divider of 0 gives a half of exactly 3 cycles. A divider of 255 with exponent 4 gives 4083 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Master enable; 0 releases the line and stops the strobes |
| low_div | input | 8 | Low-half divider |
| high_div | input | 8 | High-half divider |
| exp_sel | input | 3 | Power-of-two exponent, capped at 4 |
| scl_sense | input | 1 | SCL as seen on the bus (1 = high) |
| scl_req | output | 1 | Requested SCL level (0 = pull low, 1 = release) |
| tick_low_end | output | 1 | Strobe in the last cycle of each low half |
| tick_high_mid | output | 1 | Strobe in the middle of each high half |

## Verification
The timing is tried with the following configurations:

- **Zero dividers.** These isolate the fixed three-cycle overhead.
- **Full-scale dividers.** These reach the widest count.
- **Strongly unequal dividers.** These show that the two halves are timed independently.
- **Exponents 5 to 7.** These must match exponent 4 exactly.

Stretch lengths from zero to several cycles separate a counter that stalls on the sensed line from one that ignores it. The position of the mid-high strobe shows the same distinction. Configuration changes in the middle of a period tell a capture-at-low-start design apart from one that uses the live inputs. Disables during either half, and a reset in mid-period, show that the line is released and the next low half is full length.

// File: rtl/i2c_scl_gen_pkg.sv
package i2c_scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  localparam int NUM_PHASES = 2;
  localparam int IDX_LOW    = 0;
  localparam int IDX_HIGH   = 1;

endpackage

// File: rtl/i2c_scl_rst_sync.sv
module i2c_scl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/i2c_scl_cfg_latch.sv
module i2c_scl_cfg_latch
  import i2c_scl_gen_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int EXP_W    = 3,
  parameter int EXP_MAX  = 4,
  parameter int OVERHEAD = 3,
  parameter int LEN_W    = DIV_W + EXP_MAX + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] low_div,
  input  logic [DIV_W-1:0] high_div,
  input  logic [EXP_W-1:0] exp_sel,
  output logic [LEN_W-1:0] low_len,
  output logic [LEN_W-1:0] high_len,
  output logic [LEN_W-1:0] high_mid,
  output logic [EXP_W-1:0] exp_eff
);

  logic [EXP_W-1:0] exp_clamp;
  logic [EXP_W-1:0] exp_eff_d;

  // exponent cap: anything past EXP_MAX behaves as EXP_MAX
  always_comb begin
    if (exp_sel > EXP_W'(EXP_MAX)) begin
      exp_clamp = EXP_W'(EXP_MAX);
    end else begin
      exp_clamp = exp_sel;
    end
  end

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
    logic [DIV_W-1:0] div_sel;
    logic [LEN_W-1:0] len_d;
    logic [LEN_W-1:0] len_q;

    assign div_sel = (g == IDX_LOW) ? low_div : high_div;

    always_comb begin
      len_d = len_q;
      if (load) begin
        len_d = (LEN_W'(div_sel) << exp_clamp) + LEN_W'(OVERHEAD);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        len_q <= LEN_W'(OVERHEAD);
      end else begin
        len_q <= len_d;
      end
    end
  end

  always_comb begin
    exp_eff_d = exp_eff;
    if (load) begin
      exp_eff_d = exp_clamp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_eff <= '0;
    end else begin
      exp_eff <= exp_eff_d;
    end
  end

  assign low_len  = g_phase[IDX_LOW].len_q;
  assign high_len = g_phase[IDX_HIGH].len_q;
  assign high_mid = high_len >> 1;

endmodule

// File: rtl/i2c_scl_phase_cnt.sv
module i2c_scl_phase_cnt #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  output logic [W-1:0] cnt
);

  logic         cnt_en;
  logic [W-1:0] cnt_d;

  assign cnt_en = clr | adv;

  always_comb begin
    if (clr) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
  import i2c_scl_gen_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int EXP_W    = 3,
  parameter int EXP_MAX  = 4,
  parameter int OVERHEAD = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] low_div,
  input  logic [DIV_W-1:0] high_div,
  input  logic [EXP_W-1:0] exp_sel,
  input  logic             scl_sense,
  output logic             scl_req,
  output logic             tick_low_end,
  output logic             tick_high_mid
);

  localparam int LEN_W = DIV_W + EXP_MAX + 1;

  logic             rst_sync_n;
  phase_e           state_q;
  phase_e           state_d;
  logic             load_cfg;
  logic             cnt_clr;
  logic             cnt_adv;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] low_len;
  logic [LEN_W-1:0] high_len;
  logic [LEN_W-1:0] high_mid;
  logic [EXP_W-1:0] exp_eff;
  logic             low_last;
  logic             high_last;
  logic             in_low;
  logic             in_high;

  i2c_scl_rst_sync #(
    .STAGES(2)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_sync_n)
  );

  i2c_scl_cfg_latch #(
    .DIV_W   (DIV_W),
    .EXP_W   (EXP_W),
    .EXP_MAX (EXP_MAX),
    .OVERHEAD(OVERHEAD),
    .LEN_W   (LEN_W)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (load_cfg),
    .low_div (low_div),
    .high_div(high_div),
    .exp_sel (exp_sel),
    .low_len (low_len),
    .high_len(high_len),
    .high_mid(high_mid),
    .exp_eff (exp_eff)
  );

  i2c_scl_phase_cnt #(
    .W(LEN_W)
  ) u_cnt (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .clr  (cnt_clr),
    .adv  (cnt_adv),
    .cnt  (cnt_q)
  );

  assign in_low    = (state_q == PH_LOW);
  assign in_high   = (state_q == PH_HIGH);
  assign low_last  = (cnt_q == (low_len - LEN_W'(1)));
  assign high_last = (cnt_q == (high_len - LEN_W'(1)));

  // phase sequencing
  always_comb begin
    state_d  = state_q;
    load_cfg = 1'b0;
    cnt_clr  = 1'b0;
    cnt_adv  = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        cnt_clr = 1'b1;
        if (enable) begin
          state_d  = PH_LOW;
          load_cfg = 1'b1;
        end
      end
      PH_LOW: begin
        if (!enable) begin
          state_d = PH_IDLE;
          cnt_clr = 1'b1;
        end else if (low_last) begin
          state_d = PH_HIGH;
          cnt_clr = 1'b1;
        end else begin
          cnt_adv = 1'b1;
        end
      end
      PH_HIGH: begin
        if (!enable) begin
          state_d = PH_IDLE;
          cnt_clr = 1'b1;
        end else if (scl_sense) begin
          if (high_last) begin
            state_d  = PH_LOW;
            load_cfg = 1'b1;
            cnt_clr  = 1'b1;
          end else begin
            cnt_adv = 1'b1;
          end
        end
      end
      default: begin
        state_d = PH_IDLE;
        cnt_clr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= PH_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign scl_req       = ~(enable & in_low);
  assign tick_low_end  = enable & in_low & low_last;
  assign tick_high_mid = enable & in_high & scl_sense & (cnt_q == high_mid);

endmodule

// File: rtl/i2c_scl_gen_chk.sv
module i2c_scl_gen_chk #(
  parameter int LEN_W   = 13,
  parameter int EXP_W   = 3,
  parameter int EXP_MAX = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             scl_sense,
  input logic             scl_req,
  input logic             tick_low_end,
  input logic             tick_high_mid,
  input logic             in_high,
  input logic             load_cfg,
  input logic [LEN_W-1:0] cnt_q,
  input logic [LEN_W-1:0] low_len,
  input logic [LEN_W-1:0] high_len,
  input logic [EXP_W-1:0] exp_eff
);

  // R1: a low half never ends on the cycle after it starts
  p_low_min_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_req) |=> (!scl_req || !enable));

  // R3: the captured exponent never exceeds the cap
  p_exp_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exp_eff <= EXP_W'(EXP_MAX));

  // R4: a high half with the line seen low keeps its count
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_high && enable && !scl_sense) |=> $stable(cnt_q));

  // R5: lengths move only on a capture edge
  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_cfg |=> ($stable(low_len) && $stable(high_len)));

  // R6: the low-end strobe is followed by a released line
  p_low_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_low_end |=> (scl_req || !enable));

  // R7: the mid strobe only while the line is released and seen high
  p_mid_sensed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_high_mid |-> (scl_req && scl_sense));

  // R8: disabled means released and silent
  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (scl_req && !tick_low_end && !tick_high_mid));

endmodule

bind i2c_scl_gen i2c_scl_gen_chk #(
  .LEN_W  (LEN_W),
  .EXP_W  (EXP_W),
  .EXP_MAX(EXP_MAX)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .enable       (enable),
  .scl_sense    (scl_sense),
  .scl_req      (scl_req),
  .tick_low_end (tick_low_end),
  .tick_high_mid(tick_high_mid),
  .in_high      (in_high),
  .load_cfg     (load_cfg),
  .cnt_q        (cnt_q),
  .low_len      (low_len),
  .high_len     (high_len),
  .exp_eff      (exp_eff)
);

// File: tb/test_i2c_scl_gen.sv
module test_i2c_scl_gen;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic [7:0] low_div;
  logic [7:0] high_div;
  logic [2:0] exp_sel;
  logic       scl_sense;
  logic       scl_req;
  logic       tick_low_end;
  logic       tick_high_mid;

  int unsigned stretch_len = 0;
  int unsigned st_cnt      = 0;
  logic        st_hold     = 1'b0;
  string       seg_tag     = "init";

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_scl_gen i_i2c_scl_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .low_div      (low_div),
    .high_div     (high_div),
    .exp_sel      (exp_sel),
    .scl_sense    (scl_sense),
    .scl_req      (scl_req),
    .tick_low_end (tick_low_end),
    .tick_high_mid(tick_high_mid)
  );

  // slave model: holds the line low for stretch_len cycles after release
  assign scl_sense = scl_req & ~st_hold;

  always @(posedge clk) begin
    if (!scl_req) begin
      st_cnt  <= stretch_len;
      st_hold <= (stretch_len != 0);
    end else if (st_cnt != 0) begin
      st_cnt  <= st_cnt - 1;
      st_hold <= (st_cnt > 1);
    end else begin
      st_hold <= 1'b0;
    end
  end

  function automatic int half_len(int div, int e);
    int ee;
    ee = (e > 4) ? 4 : e;
    return (div << ee) + 3;
  endfunction

  task automatic check(bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s [%s]: actual %0d expected %0d", what, seg_tag, act, exp);
    end
  endtask

  // monitor: measures each half at negedges
  bit in_lo = 0, in_hi = 0;
  int run_len = 0, exp_l = 0, exp_h = 0, exp_s = 0;
  int t_cnt = 0, t_pos = 0, stray = 0;

  always @(negedge clk) begin
    if (!rst_n || !enable) begin
      check(scl_req === 1'b1 && tick_low_end === 1'b0 && tick_high_mid === 1'b0,
            !rst_n ? "R9 released in reset" : "R8 released when disabled",
            int'({scl_req, tick_low_end, tick_high_mid}), 4);
      in_lo = 0;
      in_hi = 0;
    end else if (scl_req === 1'b0) begin
      if (!in_lo) begin
        if (in_hi) begin
          check(run_len == exp_h + exp_s, "R2 high length (R4 stretch)", run_len, exp_h + exp_s);
          check(t_cnt == 1 && stray == 0, "R7 one mid strobe", t_cnt + stray, 1);
          check(t_pos == exp_s + (exp_h >> 1), "R7 mid strobe position", t_pos, exp_s + (exp_h >> 1));
        end
        exp_l = half_len(int'(low_div), int'(exp_sel));
        exp_h = half_len(int'(high_div), int'(exp_sel));
        in_lo = 1; in_hi = 0; run_len = 0; t_cnt = 0; t_pos = -1; stray = 0;
      end
      if (tick_low_end) begin t_cnt++; t_pos = run_len; end
      if (tick_high_mid) stray++;
      run_len++;
    end else begin
      if (in_lo) begin
        check(run_len == exp_l, "R1 low length", run_len, exp_l);
        check(t_cnt == 1 && stray == 0, "R6 one low-end strobe", t_cnt + stray, 1);
        check(t_pos == exp_l - 1, "R6 low-end strobe position", t_pos, exp_l - 1);
        in_lo = 0; in_hi = 1; run_len = 0; t_cnt = 0; t_pos = -1; stray = 0;
        exp_s = int'(st_cnt);
      end
      if (in_hi) begin
        if (tick_high_mid) begin t_cnt++; t_pos = run_len; end
        if (tick_low_end) stray++;
        run_len++;
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired [%s]: actual 1 expected 0", seg_tag);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    // R9: reset wins over enable
    seg_tag = "R9 reset"; rst_n = 1'b0; enable = 1'b1;
    low_div = 8'd5; high_div = 8'd5; exp_sel = 3'd0;
    step(5);
    rst_n = 1'b1;
    step(60);
    // R10: smallest halves
    seg_tag = "R10 zero dividers"; low_div = 8'd0; high_div = 8'd0;
    step(40);
    // R10: widest halves
    seg_tag = "R10 full scale"; low_div = 8'd255; high_div = 8'd255; exp_sel = 3'd4;
    step(3 * 8166 + 40);
    // R3: exponent cap
    for (int e = 5; e < 8; e++) begin
      seg_tag = "R3 exponent cap"; low_div = 8'd10; high_div = 8'd3; exp_sel = 3'(e);
      step(600);
    end
    // R2 unequal halves, R4 stretching
    seg_tag = "R4 stretch"; low_div = 8'd2; high_div = 8'd6; exp_sel = 3'd1;
    stretch_len = 4; step(300);
    stretch_len = 1; step(200);
    stretch_len = 0; low_div = 8'd1; high_div = 8'd60; step(400);
    // R5: change in the middle of a period
    seg_tag = "R5 mid-period change"; low_div = 8'd20; high_div = 8'd20; exp_sel = 3'd0;
    step(120);
    do step(1); while (scl_req !== 1'b0);
    step(5);
    low_div = 8'd2; high_div = 8'd30;
    step(400);
    // R8: disable in each half
    seg_tag = "R8 disable"; enable = 1'b0; step(7);
    enable = 1'b1; step(200);
    do step(1); while (scl_req !== 1'b1);
    step(2); enable = 1'b0; step(1); enable = 1'b1;
    step(200);
    // R9: reset in mid-period
    seg_tag = "R9 reset mid-period"; stretch_len = 2;
    do step(1); while (scl_req !== 1'b0);
    step(3); rst_n = 1'b0; step(3); rst_n = 1'b1;
    step(300);
    // random mix
    seg_tag = "random";
    for (int i = 0; i < 40; i++) begin
      exp_sel     = 3'($urandom % 8);
      low_div     = 8'((exp_sel >= 3) ? ($urandom % 16) : ($urandom % 64));
      high_div    = 8'((exp_sel >= 3) ? ($urandom % 16) : ($urandom % 64));
      stretch_len = $urandom % 6;
      if ($urandom % 8 == 0) begin
        enable = 1'b0; step(1 + $urandom % 4); enable = 1'b1;
      end
      step(100 + $urandom % 700);
    end
    finish_run();
  end

endmodule